// File: doc/BRIEF.md
# Tearing-Effect Line Trigger

This block listens to the tearing-effect sync signals that an external display panel drives. It raises a one-cycle start pulse that a frame-transfer engine uses to begin writing a new image without visible tearing. The panel may report sync on one wire or on two. With one wire, horizontal and vertical sync pulses share it and are told apart by how long each pulse stays active. With two wires, one carries horizontal sync and the other vertical sync.

Software programs the operating mode, a minimum active width in clock ticks for each kind of pulse, an active level for each input and a target line. After every vertical sync the block counts horizontal syncs. When the count reaches the target line, it fires the trigger once. Both pins pass through two-flop synchronisers before their pulses are measured. Valid settings follow these rules: the horizontal minimum is at least 2, the vertical minimum is at least 2 in two-wire mode and at least 4 in one-wire mode, and the two minimums differ. The block does not check these settings itself.

Top module: `tsync_trigger`

## Requirements
- R1: `mode_i` encodes 0 = off, 1 = one-wire, 2 = two-wire, and 3 behaves as off. In an off mode no trigger is produced and the frame is disarmed.
- R2: Each of `pol_a_i` and `pol_b_i` selects the active level of its line: 1 means active-high and 0 means active-low. In one-wire mode the shared line is `te_a_i` with polarity `pol_a_i`.
- R3: In one-wire mode, a pulse on `te_a_i` whose active length is at least `vs_min_i` ticks is a vertical sync, even when it arrives in the middle of a frame.
- R4: In one-wire mode, a pulse shorter than `vs_min_i` but at least `hs_min_i` ticks is a horizontal sync. A pulse shorter than both minimums is ignored.
- R5: In two-wire mode, a pulse on `te_a_i` of at least `hs_min_i` ticks is a horizontal sync, whatever its length above that. A pulse on `te_b_i` of at least `vs_min_i` ticks is a vertical sync. Shorter pulses on either line are ignored.
- R6: A vertical sync sets the line count to 0 and arms the frame. Each horizontal sync adds one to the count. The trigger fires when an armed count equals the 11-bit `line_i` (0 to 2047), and a target of 0 fires on the vertical sync itself.
- R7: `trig_o` is high for exactly one cycle, at most once per frame. Further horizontal syncs do not fire it again until the next vertical sync re-arms the frame.
- R8: A pulse's active length is the number of rising clock edges at which the pin is sampled active. It is classified when the pulse ends. If the pin is first sampled inactive at rising edge k and that pulse completes a match, `trig_o` is high from edge k+3 until edge k+4.
- R9: Out of reset `trig_o` is low and the frame is disarmed, so horizontal syncs seen before the first vertical sync never trigger.
- R10: A width exactly equal to a minimum qualifies: a length of `hs_min_i` is a horizontal sync and `hs_min_i` - 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Operating mode (0 off, 1 one-wire, 2 two-wire) |
| hs_min_i | input | CNT_W | Minimum horizontal sync width in ticks |
| vs_min_i | input | CNT_W | Minimum vertical sync width in ticks |
| pol_a_i | input | 1 | Active level of line A (1 = high) |
| pol_b_i | input | 1 | Active level of line B (1 = high) |
| line_i | input | 11 | Target line after vertical sync |
| te_a_i | input | 1 | Line A: shared sync (one-wire) or horizontal sync (two-wire) |
| te_b_i | input | 1 | Line B: vertical sync (two-wire) |
| trig_o | output | 1 | One-cycle start trigger |

## Verification
The trigger logic is exercised with pulse trains on the shared line. These include widths exactly at each minimum and one tick below it, widths between the two minimums, and a long pulse in the middle of a frame. Together they separate the glitch, horizontal and vertical classes and show that a late vertical sync restarts the count. Two-wire trains put over-long pulses on the horizontal line and short pulses on the vertical line, which shows that classification follows the wire and not the width. Active-low runs on each line confirm the polarity controls. Target lines of 0, small values and 2047 test the count against the target, and repeated frames with surplus horizontal syncs test single firing and re-arming. Trains sent with the mode at 0 and at 3 must stay silent.

// File: rtl/tsync_pkg.sv
package tsync_pkg;
  typedef enum logic [1:0] {
    TS_OFF     = 2'd0,
    TS_ONE_PIN = 2'd1,
    TS_TWO_PIN = 2'd2,
    TS_RSVD    = 2'd3
  } ts_mode_e;

  localparam int unsigned LINE_W = 11;
  localparam int unsigned NUM_IN = 2;

  typedef struct packed {
    logic hs;
    logic vs;
  } ts_evt_t;
endpackage

// File: rtl/tsync_rst_sync.sv
module tsync_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/tsync_in_sync.sv
module tsync_in_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic pol_i,
  output logic lvl_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;
  logic              norm;

  // active level normalised to high before the metastability chain
  assign norm = pol_i ? pin_i : ~pin_i;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = norm;
    end else begin : g_many
      always_comb sh_d = {sh_q[STAGES-2:0], norm};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign lvl_o = sh_q[STAGES-1];
endmodule

// File: rtl/tsync_width_meas.sv
module tsync_width_meas #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_i,
  output logic             end_o,
  output logic [CNT_W-1:0] len_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             prev_q, prev_d;

  always_comb begin
    prev_d = lvl_i;
    if (!lvl_i)                cnt_d = '0;
    else if (cnt_q == CNT_MAX) cnt_d = cnt_q;
    else                       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      prev_q <= prev_d;
    end
  end

  assign end_o = prev_q & ~lvl_i;
  assign len_o = cnt_q;

  // R8: an inactive sample leaves the width counter cleared
  a_r8_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lvl_i |=> (cnt_q == '0));
  // R10: active samples grow the measured width by one tick
  a_r10_width_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/tsync_line_trig.sv
module tsync_line_trig
  import tsync_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  ts_evt_t           evt_i,
  input  logic [LINE_W-1:0] line_i,
  output logic              trig_o
);
  localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

  logic [LINE_W-1:0] cnt_q, cnt_d;
  logic              armed_q, armed_d;
  logic              trig_q, trig_d;
  logic              cnt_en;
  logic              hit;

  assign hit    = armed_q & (cnt_q == line_i);
  assign cnt_en = en_i & (evt_i.vs | evt_i.hs);

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    trig_d  = hit & en_i;
    if (!en_i) begin
      armed_d = 1'b0;
    end else if (evt_i.vs) begin
      cnt_d   = '0;
      armed_d = 1'b1;
    end else begin
      if (hit) armed_d = 1'b0;
      if (evt_i.hs && cnt_q != LINE_MAX) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      trig_q  <= trig_d;
    end
  end

  assign trig_o = trig_q;

  // R7: the trigger never lasts longer than one cycle
  a_r7_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);
  // R6: vertical sync restarts the line count
  a_r6_vs_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && evt_i.vs) |=> (cnt_q == '0 && armed_q));
  // R6: horizontal sync advances the line count by one
  a_r6_hs_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && evt_i.hs && !evt_i.vs && cnt_q != LINE_MAX)
      |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R1: a disabled mode keeps the next cycle quiet
  a_r1_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !trig_o);
endmodule

// File: rtl/tsync_trigger.sv
module tsync_trigger
  import tsync_pkg::*;
#(
  parameter int unsigned CNT_W     = 6,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [CNT_W-1:0]  hs_min_i,
  input  logic [CNT_W-1:0]  vs_min_i,
  input  logic              pol_a_i,
  input  logic              pol_b_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              te_a_i,
  input  logic              te_b_i,
  output logic              trig_o
);
  logic                       rst_sync_n;
  logic [NUM_IN-1:0]          pins;
  logic [NUM_IN-1:0]          pols;
  logic [NUM_IN-1:0]          lvl;
  logic [NUM_IN-1:0]          pend;
  logic [NUM_IN-1:0][CNT_W-1:0] plen;
  ts_mode_e                   mode;
  ts_evt_t                    evt;
  logic                       en;

  assign pins = {te_b_i, te_a_i};
  assign pols = {pol_b_i, pol_a_i};
  assign mode = ts_mode_e'(mode_i);

  tsync_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  generate
    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_line
      tsync_in_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_sync_n),
        .pin_i  (pins[gi]),
        .pol_i  (pols[gi]),
        .lvl_o  (lvl[gi])
      );
      tsync_width_meas #(.CNT_W(CNT_W)) u_meas (
        .clk_i  (clk_i),
        .rst_ni (rst_sync_n),
        .lvl_i  (lvl[gi]),
        .end_o  (pend[gi]),
        .len_o  (plen[gi])
      );
    end
  endgenerate

  always_comb begin
    evt = '0;
    en  = 1'b0;
    unique case (mode)
      TS_ONE_PIN: begin
        en = 1'b1;
        if (pend[0]) begin
          if (plen[0] >= vs_min_i)      evt.vs = 1'b1;
          else if (plen[0] >= hs_min_i) evt.hs = 1'b1;
        end
      end
      TS_TWO_PIN: begin
        en     = 1'b1;
        evt.hs = pend[0] && (plen[0] >= hs_min_i);
        evt.vs = pend[1] && (plen[1] >= vs_min_i);
      end
      default: begin
        en = 1'b0;
      end
    endcase
  end

  tsync_line_trig u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .en_i   (en),
    .evt_i  (evt),
    .line_i (line_i),
    .trig_o (trig_o)
  );

  // R4: a sub-threshold pulse on the shared wire produces no event
  a_r4_glitch_drop: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (mode == TS_ONE_PIN && pend[0] && plen[0] < hs_min_i && plen[0] < vs_min_i)
      |-> !(evt.hs || evt.vs));
  // R5: line B never yields horizontal sync in two-wire mode
  a_r5_b_is_vs: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (mode == TS_TWO_PIN && !pend[0]) |-> !evt.hs);
endmodule

// File: tb/tsync_trigger_bench.sv
module tsync_trigger_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic [5:0]  hs_min, vs_min;
  logic        pol_a, pol_b;
  logic [10:0] line;
  logic        te_a, te_b;
  logic        trig;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int q[$];
  string cur_req = "R9";
  bit run_mon = 1'b0;

  int  m_cnt   = 0;
  bit  m_armed = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tsync_trigger u_tsync_trigger (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .hs_min_i(hs_min),
    .vs_min_i(vs_min), .pol_a_i(pol_a), .pol_b_i(pol_b), .line_i(line),
    .te_a_i(te_a), .te_b_i(te_b), .trig_o(trig)
  );

  task automatic fail_line(string req, int act, int exp);
    fails++;
    $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
  endtask

  // monitor: pops expected trigger cycles
  always @(negedge clk) begin
    if (run_mon && trig) begin
      checks++;
      if (q.size() == 0) fail_line({cur_req, " unexpected trigger at cycle"}, cyc, -1);
      else begin
        int e;
        e = q.pop_front();
        if (e != cyc) fail_line({cur_req, " trigger cycle"}, cyc, e);
      end
    end
  end

  // model from requirements, pushes expected cycle
  task automatic model_event(int ch, int len, int end_c);
    bit vs_e, hs_e;
    vs_e = 0; hs_e = 0;
    if (mode == 2'd1 && ch == 0) begin
      if (len >= vs_min) vs_e = 1;
      else if (len >= hs_min) hs_e = 1;
    end else if (mode == 2'd2) begin
      if (ch == 0 && len >= hs_min) hs_e = 1;
      if (ch == 1 && len >= vs_min) vs_e = 1;
    end
    if (vs_e) begin
      m_cnt = 0; m_armed = 1;
      if (line == 0) begin q.push_back(end_c + 4); m_armed = 0; end
    end else if (hs_e) begin
      if (m_cnt < 2047) m_cnt++;
      if (m_armed && m_cnt == line) begin q.push_back(end_c + 4); m_armed = 0; end
    end
  endtask

  task automatic pulse(int ch, int len, int gap);
    logic act;
    act = (ch == 0) ? pol_a : pol_b;
    @(negedge clk);
    if (ch == 0) te_a = act; else te_b = act;
    repeat (len) @(negedge clk);
    if (ch == 0) te_a = ~act; else te_b = ~act;
    model_event(ch, len, cyc);
    repeat (gap) @(negedge clk);
  endtask

  task automatic drain(string req);
    repeat (8) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fail_line({req, " missed triggers"}, q.size(), 0);
      q.delete();
    end
  endtask

  task automatic set_mode(logic [1:0] m);
    @(negedge clk);
    mode = m;
    if (m == 2'd0 || m == 2'd3) m_armed = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_pol(logic a, logic b);
    @(negedge clk);
    pol_a = a; te_a = ~a;
    pol_b = b; te_b = ~b;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(4 * 190000);
    fail_line("watchdog", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 2'd1; hs_min = 6'd3; vs_min = 6'd6;
    pol_a = 1'b1; pol_b = 1'b1; line = 11'd2; te_a = 1'b0; te_b = 1'b0;
    repeat (4) @(negedge clk);
    checks++;
    if (trig !== 1'b0) fail_line("R9 reset trig", trig, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    run_mon = 1'b1;

    // R9: horizontal syncs before any vertical sync stay silent
    cur_req = "R9";
    repeat (4) pulse(0, 4, 6);
    drain("R9");

    // R6 / R8: vertical then two horizontal syncs reach line 2
    cur_req = "R6";
    pulse(0, 8, 6); pulse(0, 4, 6); pulse(0, 4, 6);
    drain("R6");
    // R7: surplus syncs do nothing, next frame re-arms
    cur_req = "R7";
    pulse(0, 4, 6); pulse(0, 4, 6);
    drain("R7");
    pulse(0, 7, 6); pulse(0, 3, 6); pulse(0, 3, 6); pulse(0, 3, 6);
    drain("R7");

    // R10: exact minimum widths qualify, one below is ignored
    cur_req = "R10";
    line = 11'd1;
    pulse(0, 6, 6); pulse(0, 2, 6); pulse(0, 3, 6);
    drain("R10");

    // R4: width between the minimums counts as horizontal sync
    cur_req = "R4";
    line = 11'd2;
    pulse(0, 6, 6); pulse(0, 1, 6); pulse(0, 5, 6); pulse(0, 5, 6);
    drain("R4");

    // R3: a long pulse mid-frame restarts the count
    cur_req = "R3";
    line = 11'd3;
    pulse(0, 9, 6); pulse(0, 4, 6); pulse(0, 4, 6);
    pulse(0, 12, 6); pulse(0, 4, 6); pulse(0, 4, 6); pulse(0, 4, 6);
    drain("R3");

    // R6: target 0 fires on the vertical sync
    cur_req = "R6";
    line = 11'd0;
    pulse(0, 6, 6); pulse(0, 4, 6);
    drain("R6");

    // R2: active-low shared line
    cur_req = "R2";
    set_pol(1'b0, 1'b1);
    line = 11'd1;
    pulse(0, 7, 6); pulse(0, 4, 6);
    drain("R2");
    set_pol(1'b1, 1'b1);

    // R5: two-wire classification follows the wire
    cur_req = "R5";
    hs_min = 6'd3; vs_min = 6'd2;
    set_mode(2'd2);
    line = 11'd2;
    pulse(1, 2, 6); pulse(0, 2, 6); pulse(1, 1, 6);
    pulse(0, 10, 6); pulse(0, 3, 6);
    drain("R5");
    // R2: active-low vertical line in two-wire mode
    cur_req = "R2";
    set_pol(1'b1, 1'b0);
    line = 11'd1;
    pulse(1, 3, 6); pulse(0, 3, 6);
    drain("R2");
    set_pol(1'b1, 1'b1);

    // R1: modes 0 and 3 never trigger
    cur_req = "R1";
    line = 11'd0;
    set_mode(2'd0);
    pulse(1, 4, 6); pulse(0, 8, 6); pulse(0, 3, 6);
    drain("R1");
    set_mode(2'd3);
    pulse(1, 4, 6); pulse(0, 8, 6);
    drain("R1");

    // R6: full-range target 2047 in one-wire mode
    cur_req = "R6";
    hs_min = 6'd2; vs_min = 6'd4;
    set_mode(2'd1);
    line = 11'd2047;
    pulse(0, 4, 4);
    for (int i = 0; i < 2048; i++) pulse(0, 2, 3);
    drain("R6");

    run_mon = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule